// File: doc/BRIEF.md
# Half-Width Sequencing Vector Execution Lane

This block executes vector operations of two widths, 256 and 512 bits, on one 256-bit pipelined datapath. An operation enters through a valid/ready issue port with an opcode, a width flag, two 512-bit operand buses and a tag. A narrow operation uses only the low 256 bits of each operand. A wide operation is accepted as one item. Inside the lane it is then split into a low half and a high half. The low half enters the pipe in the cycle after acceptance, and the high half enters in the next cycle.

Each half takes the same number of pipe cycles as a narrow operation, so the high half's result trails the low half's by one cycle. A skid register at the output holds the low half's result until the high half arrives. The result port then presents both halves together with a single valid pulse.

The lane keeps no width mode. Narrow and wide operations may be mixed freely. The only cost of a wide operation is the one issue cycle its high half occupies. The opcodes are lanewise add, subtract, AND, OR and XOR on 32-bit elements, plus a whole-vector OR-reduce. The reduce produces a single "any bit set" flag, and for a wide operand it merges the partial flags of both halves.

Top module: `simd_half_lane`

## Requirements
- R1: For a narrow operation (in_wide=0) accepted in cycle c, out_valid is high in cycle c+3 and low in cycles c+1 and c+2. The low 256 bits of out_data hold the lanewise result over 32-bit elements of operand A and operand B, using the in_op code: 0 add, 1 subtract (A-B), 2 AND, 3 OR, 4 XOR.
- R2: For a wide operation (in_wide=1) accepted in cycle c, out_valid is high only in cycle c+4 and out_wide=1. All 512 bits of out_data hold the lanewise result, with the low element half in bits 255:0.
- R3: In the cycle after a wide operation is accepted, in_ready is 0. In every other cycle outside reset it is 1, so narrow operations can be accepted in consecutive cycles.
- R4: Narrow and wide operations can be mixed in any order without idle cycles beyond those of R3. Each operation keeps its own latency from R1, R2 or R6.
- R5: Each accepted operation produces exactly one out_valid pulse. Results appear in issue order, and out_tag carries the in_tag of the operation.
- R6: in_op code 5 is OR-reduce. out_any is the OR of every bit of operand A over the active width (256 or 512 bits), and operand B is ignored. out_data is zero. The latency is 3 cycles when narrow and 4 cycles when wide.
- R7: Arithmetic is modulo 2^32 within each 32-bit element. No carry or borrow crosses an element boundary.
- R8: A synchronous active-high rst makes in_ready 1 and out_valid 0. An operation in flight when rst is asserted produces no result.
- R9: For a narrow result, out_data bits 511:256 are zero and out_wide=0, whatever the upper operand bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue request |
| in_ready | output | 1 | Lane can accept an operation this cycle |
| in_op | input | 3 | Operation code |
| in_wide | input | 1 | 1 = 512-bit operation, 0 = 256-bit |
| in_a | input | 512 | Operand A |
| in_b | input | 512 | Operand B |
| in_tag | input | 4 | Tag returned with the result |
| out_valid | output | 1 | Result valid, one cycle per operation |
| out_wide | output | 1 | Result is 512 bits wide |
| out_tag | output | 4 | Tag of the finishing operation |
| out_data | output | 512 | Lanewise result |
| out_any | output | 1 | OR-reduce result |

## Verification
A new operation can be accepted in the same cycle that an earlier wide operation's high half is still moving through the pipe. Also, a narrow result can leave the output in the cycle right after a wide result has been joined from the skid register. The directed sequence provokes both cases. It issues a narrow operation, then a wide operation, then holds a third request through the ready bubble, then issues two more operations back to back, and ends with wide and narrow reductions. At every cycle the bench compares out_valid, tag, data and the reduce flag against the cycle-by-cycle schedule worked out from R1 to R6. This shows that the skid capture and the next output do not disturb each other.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 3'd0,
      OP_SUB   = 3'd1,
      OP_AND   = 3'd2,
      OP_OR    = 3'd3,
      OP_XOR   = 3'd4,
      OP_ORRED = 3'd5
   } lane_op_e;
endpackage

// File: rtl/lane_issue_split.sv
module lane_issue_split
   import simd_lane_pkg::*;
#(
   parameter int HALF_W = 256,
   parameter int TAG_W  = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [OP_W-1:0]     in_op,
   input  logic                in_wide,
   input  logic [2*HALF_W-1:0] in_a,
   input  logic [2*HALF_W-1:0] in_b,
   input  logic [TAG_W-1:0]    in_tag,
   output logic                in_ready,
   output logic                s_valid,
   output logic [OP_W-1:0]     s_op,
   output logic                s_wide,
   output logic                s_upper,
   output logic [TAG_W-1:0]    s_tag,
   output logic [HALF_W-1:0]   s_a,
   output logic [HALF_W-1:0]   s_b
);
   // High half waiting for its slot at the pipe input
   logic                pend_q;
   logic [HALF_W-1:0]   hi_a_q, hi_b_q;
   logic [OP_W-1:0]     hi_op_q;
   logic [TAG_W-1:0]    hi_tag_q;
   logic                take;

   assign in_ready = !pend_q;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q  <= 1'b0;
         s_valid <= 1'b0;
      end else if (pend_q) begin
         s_valid <= 1'b1;
         s_upper <= 1'b1;
         s_wide  <= 1'b1;
         s_op    <= hi_op_q;
         s_tag   <= hi_tag_q;
         s_a     <= hi_a_q;
         s_b     <= hi_b_q;
         pend_q  <= 1'b0;
      end else if (take) begin
         s_valid  <= 1'b1;
         s_upper  <= 1'b0;
         s_wide   <= in_wide;
         s_op     <= in_op;
         s_tag    <= in_tag;
         s_a      <= in_a[HALF_W-1:0];
         s_b      <= in_b[HALF_W-1:0];
         pend_q   <= in_wide;
         hi_a_q   <= in_a[2*HALF_W-1:HALF_W];
         hi_b_q   <= in_b[2*HALF_W-1:HALF_W];
         hi_op_q  <= in_op;
         hi_tag_q <= in_tag;
      end else begin
         s_valid <= 1'b0;
      end
   end

   p_ready_drop_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_wide) |=> !in_ready);

   p_ready_back_r3: assert property (@(posedge clk) disable iff (rst)
      !in_ready |=> in_ready);

   p_upper_follows_r2: assert property (@(posedge clk) disable iff (rst)
      (s_valid && s_upper) |-> $past(s_valid && s_wide && !s_upper));
endmodule

// File: rtl/lane_alu.sv
module lane_alu
   import simd_lane_pkg::*;
#(
   parameter int HALF_W = 256,
   parameter int ELEM_W = 32
) (
   input  logic [OP_W-1:0]   op,
   input  logic [HALF_W-1:0] a,
   input  logic [HALF_W-1:0] b,
   output logic [HALF_W-1:0] data,
   output logic              any
);
   localparam int N_ELEM = HALF_W / ELEM_W;

   lane_op_e opc;
   assign opc = lane_op_e'(op);

   for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
      logic [ELEM_W-1:0] ea, eb, er;
      assign ea = a[i*ELEM_W +: ELEM_W];
      assign eb = b[i*ELEM_W +: ELEM_W];
      always_comb begin
         case (opc)
            OP_ADD:  er = ea + eb;
            OP_SUB:  er = ea - eb;
            OP_AND:  er = ea & eb;
            OP_OR:   er = ea | eb;
            OP_XOR:  er = ea ^ eb;
            default: er = '0;
         endcase
      end
      assign data[i*ELEM_W +: ELEM_W] = er;
   end

   // Partial flag of this half; merged with the other half at the output
   assign any = (opc == OP_ORRED) && (|a);
endmodule

// File: rtl/lane_delay.sv
module lane_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_v,
   input  logic [W-1:0] in_d,
   output logic         out_v,
   output logic [W-1:0] out_d
);
   logic [DEPTH-1:0] v_q;
   logic [W-1:0]     d_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q <= '0;
      end else begin
         v_q[0] <= in_v;
         for (int i = 1; i < DEPTH; i++) v_q[i] <= v_q[i-1];
      end
      d_q[0] <= in_d;
      for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
   end

   assign out_v = v_q[DEPTH-1];
   assign out_d = d_q[DEPTH-1];
endmodule

// File: rtl/lane_join.sv
module lane_join #(
   parameter int HALF_W = 256,
   parameter int TAG_W  = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                p_valid,
   input  logic                p_wide,
   input  logic                p_upper,
   input  logic                p_red,
   input  logic [TAG_W-1:0]    p_tag,
   input  logic [HALF_W-1:0]   p_data,
   input  logic                p_any,
   output logic                out_valid,
   output logic                out_wide,
   output logic [TAG_W-1:0]    out_tag,
   output logic [2*HALF_W-1:0] out_data,
   output logic                out_any
);
   logic              sk_valid, sk_any, sk_red;
   logic [HALF_W-1:0] sk_data;
   logic [TAG_W-1:0]  sk_tag;

   always_ff @(posedge clk) begin
      if (rst) begin
         sk_valid <= 1'b0;
      end else if (p_valid && p_wide && !p_upper) begin
         sk_valid <= 1'b1;
      end else if (p_valid && p_upper) begin
         sk_valid <= 1'b0;
      end
      if (p_valid && p_wide && !p_upper) begin
         sk_data <= p_data;
         sk_any  <= p_any;
         sk_tag  <= p_tag;
         sk_red  <= p_red;
      end
   end

   assign out_valid = p_valid && (!p_wide || p_upper);
   assign out_wide  = p_wide;
   assign out_tag   = p_tag;
   assign out_data  = p_wide ? {p_data, sk_data} : {{HALF_W{1'b0}}, p_data};
   assign out_any   = p_wide ? (p_any | sk_any) : p_any;

   p_upper_has_lower_r2: assert property (@(posedge clk) disable iff (rst)
      (p_valid && p_upper) |-> sk_valid);

   p_skid_drain_r2: assert property (@(posedge clk) disable iff (rst)
      sk_valid |-> (p_valid && p_upper));

   p_tag_pair_r5: assert property (@(posedge clk) disable iff (rst)
      (p_valid && p_upper) |-> (p_tag == sk_tag));

   p_red_pair_r6: assert property (@(posedge clk) disable iff (rst)
      (p_valid && p_upper) |-> (p_red == sk_red));
endmodule

// File: rtl/simd_half_lane.sv
module simd_half_lane
   import simd_lane_pkg::*;
#(
   parameter int HALF_W = 256,
   parameter int ELEM_W = 32,
   parameter int TAG_W  = 4,
   parameter int STAGES = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [2:0]          in_op,
   input  logic                in_wide,
   input  logic [2*HALF_W-1:0] in_a,
   input  logic [2*HALF_W-1:0] in_b,
   input  logic [TAG_W-1:0]    in_tag,
   output logic                out_valid,
   output logic                out_wide,
   output logic [TAG_W-1:0]    out_tag,
   output logic [2*HALF_W-1:0] out_data,
   output logic                out_any
);
   localparam int DLY  = STAGES - 1;
   localparam int PK_W = HALF_W + 1 + TAG_W + 3;

   if (STAGES < 2) begin : g_bad_stages
      $error("simd_half_lane: STAGES must be at least 2");
   end
   if (HALF_W % ELEM_W != 0) begin : g_bad_elem
      $error("simd_half_lane: HALF_W must be a multiple of ELEM_W");
   end
   if (OP_W != 3) begin : g_bad_opw
      $error("simd_half_lane: opcode width mismatch");
   end

   logic              s_valid, s_wide, s_upper;
   logic [OP_W-1:0]   s_op;
   logic [TAG_W-1:0]  s_tag;
   logic [HALF_W-1:0] s_a, s_b, alu_data;
   logic              alu_any, s_red;
   logic [PK_W-1:0]   pk_in, pk_out;
   logic              p_valid;

   lane_issue_split #(.HALF_W(HALF_W), .TAG_W(TAG_W)) i_split (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
      .in_wide(in_wide), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
      .in_ready(in_ready), .s_valid(s_valid), .s_op(s_op), .s_wide(s_wide),
      .s_upper(s_upper), .s_tag(s_tag), .s_a(s_a), .s_b(s_b));

   lane_alu #(.HALF_W(HALF_W), .ELEM_W(ELEM_W)) i_alu (
      .op(s_op), .a(s_a), .b(s_b), .data(alu_data), .any(alu_any));

   assign s_red = (lane_op_e'(s_op) == OP_ORRED);
   assign pk_in = {s_red, s_wide, s_upper, s_tag, alu_any, alu_data};

   lane_delay #(.W(PK_W), .DEPTH(DLY)) i_pipe (
      .clk(clk), .rst(rst), .in_v(s_valid), .in_d(pk_in),
      .out_v(p_valid), .out_d(pk_out));

   lane_join #(.HALF_W(HALF_W), .TAG_W(TAG_W)) i_join (
      .clk(clk), .rst(rst), .p_valid(p_valid),
      .p_red(pk_out[PK_W-1]), .p_wide(pk_out[PK_W-2]), .p_upper(pk_out[PK_W-3]),
      .p_tag(pk_out[HALF_W+1 +: TAG_W]), .p_any(pk_out[HALF_W]),
      .p_data(pk_out[HALF_W-1:0]),
      .out_valid(out_valid), .out_wide(out_wide), .out_tag(out_tag),
      .out_data(out_data), .out_any(out_any));
endmodule

// File: tb/test_simd_half_lane.sv
`timescale 1ns/1ps
module test_simd_half_lane;
   import simd_lane_pkg::*;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [2:0]   in_op = '0;
   logic         in_wide = 1'b0;
   logic [511:0] in_a = '0, in_b = '0;
   logic [3:0]   in_tag = '0;
   logic         out_valid, out_wide, out_any;
   logic [3:0]   out_tag;
   logic [511:0] out_data;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   simd_half_lane i_simd_half_lane (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
      .in_tag(in_tag), .out_valid(out_valid), .out_wide(out_wide),
      .out_tag(out_tag), .out_data(out_data), .out_any(out_any));

   typedef struct packed {
      lane_op_e    op;
      logic        wide;
      logic [31:0] sa;
      logic [31:0] sb;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{OP_ADD,   1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
      '{OP_SUB,   1'b0, 32'h0000_0000, 32'h0000_0001},
      '{OP_AND,   1'b0, 32'hF0F0_1234, 32'h0FF0_FFFF},
      '{OP_OR,    1'b0, 32'h8000_0001, 32'h0001_0000},
      '{OP_XOR,   1'b0, 32'hDEAD_BEEF, 32'h1234_5678},
      '{OP_ADD,   1'b1, 32'hFFFF_FFFF, 32'h0000_0001},
      '{OP_SUB,   1'b1, 32'h0000_0010, 32'h0000_0020},
      '{OP_OR,    1'b1, 32'h0000_0F00, 32'hA000_0000},
      '{OP_XOR,   1'b1, 32'h5555_AAAA, 32'hFFFF_0000},
      '{OP_ORRED, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF},
      '{OP_ORRED, 1'b1, 32'h0000_0000, 32'h0000_0001},
      '{OP_ORRED, 1'b1, 32'h0000_0040, 32'h0000_0000}
   };

   function automatic logic [511:0] mk_a(logic [31:0] s);
      logic [511:0] r;
      for (int i = 0; i < 16; i++)
         r[i*32 +: 32] = (s == 32'd0) ? 32'd0 : (s ^ (i * 32'h0101_0101));
      return r;
   endfunction

   function automatic logic [511:0] mk_b(logic [31:0] s);
      logic [511:0] r;
      for (int i = 0; i < 16; i++) r[i*32 +: 32] = s + i;
      return r;
   endfunction

   // Returns {any, data}
   function automatic logic [512:0] model(lane_op_e op, logic wide,
                                          logic [511:0] a, logic [511:0] b);
      logic [511:0] d = '0;
      logic         any = 1'b0;
      int n = wide ? 16 : 8;
      for (int i = 0; i < n; i++) begin
         logic [31:0] x, y;
         x = a[i*32 +: 32];
         y = b[i*32 +: 32];
         case (op)
            OP_ADD:  d[i*32 +: 32] = x + y;
            OP_SUB:  d[i*32 +: 32] = x - y;
            OP_AND:  d[i*32 +: 32] = x & y;
            OP_OR:   d[i*32 +: 32] = x | y;
            OP_XOR:  d[i*32 +: 32] = x ^ y;
            default: d[i*32 +: 32] = '0;
         endcase
      end
      if (op == OP_ORRED) any = wide ? (|a) : (|a[255:0]);
      return {any, d};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic drive(input lane_op_e op, input logic wide,
                        input logic [511:0] a, input logic [511:0] b,
                        input logic [3:0] tag);
      in_valid = 1'b1;
      in_op    = op;
      in_wide  = wide;
      in_a     = a;
      in_b     = b;
      in_tag   = tag;
   endtask

   task automatic check_result(input string req, input lane_op_e op,
                               input logic wide, input logic [511:0] a,
                               input logic [511:0] b, input logic [3:0] tag);
      logic [512:0] e;
      e = model(op, wide, a, b);
      chk(out_valid == 1'b1, req, "out_valid", 512'(out_valid), 512'(1));
      chk(out_tag == tag, "R5", "out_tag", 512'(out_tag), 512'(tag));
      chk(out_wide == wide, req, "out_wide", 512'(out_wide), 512'(wide));
      chk(out_data == e[511:0], req, "out_data", out_data, e[511:0]);
      chk(out_any == e[512], (op == OP_ORRED) ? "R6" : req, "out_any",
          512'(out_any), 512'(e[512]));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [511:0] aA, bA, aB, bB, aC, bC, aD, bD, aE, bE, aG, bG;

      // Reset state (R8)
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R8", "out_valid in reset", 512'(out_valid), 512'(0));
      chk(in_ready == 1'b1, "R8", "in_ready in reset", 512'(in_ready), 512'(1));
      rst = 1'b0;

      // Vector table: one operation at a time (R1 R2 R3 R6 R7 R9)
      for (int v = 0; v < NV; v++) begin
         logic [511:0] a, b;
         int lat;
         string req;
         a   = mk_a(VECS[v].sa);
         b   = mk_b(VECS[v].sb);
         lat = VECS[v].wide ? 4 : 3;
         req = VECS[v].wide ? "R2" : "R1";
         @(negedge clk);
         chk(in_ready == 1'b1, "R3", "ready before issue", 512'(in_ready), 512'(1));
         drive(VECS[v].op, VECS[v].wide, a, b, 4'(v));
         for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) begin
               in_valid = 1'b0;
               chk(in_ready == !VECS[v].wide, "R3", "ready after issue",
                   512'(in_ready), 512'(!VECS[v].wide));
            end
            if (k < lat)
               chk(out_valid == 1'b0, req, "early out_valid", 512'(out_valid), 512'(0));
            else
               check_result((VECS[v].wide == 1'b0 && VECS[v].op != OP_ORRED) ? "R9" : req,
                            VECS[v].op, VECS[v].wide, a, b, 4'(v));
         end
         @(negedge clk);
         chk(out_valid == 1'b0, "R5", "second pulse", 512'(out_valid), 512'(0));
      end

      // Directed mix: narrow, wide, held request through bubble, back to back, reductions
      aA = mk_a(32'h1234_5678); bA = mk_b(32'h0F0F_0F0F);
      aB = mk_a(32'hCAFE_F00D); bB = mk_b(32'h7777_1111);
      aC = mk_a(32'h0000_0005); bC = mk_b(32'h0000_0009);
      aD = mk_a(32'hFFFF_0000); bD = mk_b(32'h00FF_FF00);
      aE = 512'd1 << 511;       bE = '0;
      aG = '0;                  bG = {512{1'b1}};
      for (int k = 0; k <= 12; k++) begin
         @(negedge clk);
         case (k)
            3:  check_result("R4", OP_ADD,   1'b0, aA, bA, 4'd1);
            5:  check_result("R4", OP_XOR,   1'b1, aB, bB, 4'd2);
            6:  check_result("R4", OP_SUB,   1'b0, aC, bC, 4'd3);
            7:  check_result("R4", OP_AND,   1'b0, aD, bD, 4'd4);
            9:  check_result("R6", OP_ORRED, 1'b1, aE, bE, 4'd5);
            10: check_result("R6", OP_ORRED, 1'b0, aG, bG, 4'd6);
            default: chk(out_valid == 1'b0, "R5", "idle out_valid",
                          512'(out_valid), 512'(0));
         endcase
         case (k)
            2, 6: chk(in_ready == 1'b0, "R3", "bubble ready", 512'(in_ready), 512'(0));
            default: chk(in_ready == 1'b1, "R4", "ready", 512'(in_ready), 512'(1));
         endcase
         case (k)
            0:    drive(OP_ADD,   1'b0, aA, bA, 4'd1);
            1:    drive(OP_XOR,   1'b1, aB, bB, 4'd2);
            2, 3: drive(OP_SUB,   1'b0, aC, bC, 4'd3);
            4:    drive(OP_AND,   1'b0, aD, bD, 4'd4);
            5:    drive(OP_ORRED, 1'b1, aE, bE, 4'd5);
            7:    drive(OP_ORRED, 1'b0, aG, bG, 4'd6);
            default: in_valid = 1'b0;
         endcase
      end

      // Reset while a wide operation is in flight (R8)
      @(negedge clk);
      drive(OP_ADD, 1'b1, mk_a(32'h1), mk_b(32'h2), 4'd9);
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(in_ready == 1'b1, "R8", "ready after reset", 512'(in_ready), 512'(1));
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R8", "flushed result", 512'(out_valid), 512'(0));
      end

      finish_run();
   end
endmodule